// File: doc/BRIEF.md
# Stopwatch Controller with Lap Hold

This block is a fully synchronous stopwatch meant for a board that has two active-low push keys and a row of seven-segment digits. The first key steps a one-hot mode through three states: clear, running and stopped. The second key takes a lap snapshot while the watch runs.

Elapsed time is kept as a chain of base-10 digit counters. A one-cycle tick enable advances the chain, typically once per second. Because each digit is held directly in decimal, no divide or modulo stage is needed before display.

Both key levels pass through a two-flop synchroniser. A press is recognised from a registered copy of the previous sample, and nothing in the block is clocked by a key edge. A display select chooses between the live time and the held lap value. The chosen digits are encoded to active-low segment patterns and registered before leaving the block.

Top module: `stopwatch_lap_top`

## Requirements
- R1: After reset the mode is clear. The three mode flags are always one-hot, with exactly one of them high.
- R2: Each accepted press of the mode key moves the mode one step: clear to running, running to stopped, stopped to clear.
- R3: A press is accepted when the synchronised key sample goes from 1 to 0. A key held low for many cycles advances the mode exactly once.
- R4: Each time digit counts from 0 to 9. When a digit wraps from 9 to 0 it carries into the next digit. When every digit is 9, one more tick wraps the whole time to zero.
- R5: While the mode is clear, the live time and the lap register are held at zero and the display shows live time. This applies even if the lap value was on display before clear was entered.
- R6: In running, the live time advances by one on each cycle where the tick enable is high. In stopped, the live time does not change.
- R7: A lap-key press while running copies the live time into the lap register and toggles the display between lap and live time. The live time keeps counting while the lap value is shown.
- R8: A lap-key press in clear or stopped changes neither the lap register nor the display select.
- R9: Digit i drives bits [7i+6:7i] of the segment output. Bit order within a digit is g down to a, and the patterns are active low: 0 is 1000000, 1 is 1111001, 2 is 0100100, 9 is 0010000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| key_mode_n | input | 1 | Raw mode key level, low while pressed |
| key_lap_n | input | 1 | Raw lap key level, low while pressed |
| tick_en | input | 1 | One-cycle time-base enable |
| seg_o | output | NUM_DIGITS*7 | Registered active-low segment patterns, digit 0 in the low bits |
| mode_clear_o | output | 1 | High while the mode is clear |
| mode_run_o | output | 1 | High while running |
| mode_stop_o | output | 1 | High while stopped |

## Verification
The assertions assume that the key inputs are bounced-free levels that are each held for several clocks. They also assume that the tick enable is a plain one-cycle pulse. Under those assumptions, a press yields one detection pulse and the digits stay in decimal range.

The stimulus respects these assumptions. It changes keys and ticks only on the falling clock edge. Every key stays low for at least two cycles and is then released with a settling gap. Tick pulses are separated by an idle cycle.

The stimulus never presses both keys at once. As a result, the checks on stopped-mode hold and lap immunity are never masked by a same-cycle mode change.

// File: rtl/stopwatch_pkg.sv
package stopwatch_pkg;
  localparam int BCD_W = 4;
  localparam int SEG_W = 7;
  typedef logic [BCD_W-1:0] bcd_t;
  typedef logic [SEG_W-1:0] seg_t;
  localparam bcd_t BCD_MAX = 4'd9;
  // one-hot mode; rotation left steps clear -> run -> stop -> clear
  localparam logic [2:0] MODE_CLR  = 3'b001;
  localparam logic [2:0] MODE_RUN  = 3'b010;
  localparam logic [2:0] MODE_STOP = 3'b100;
  localparam seg_t SEG_ZERO  = 7'b1000000;
  localparam seg_t SEG_BLANK = 7'b1111111;
endpackage

// File: rtl/key_press_detect.sv
module key_press_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic key_n_i,
  output logic press_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], key_n_i};
      prev_q <= sync_q[LAST];
    end
  end

  assign press_o = prev_q & ~sync_q[LAST];

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    press_o |=> !press_o);
endmodule

// File: rtl/bcd_digit_chain.sv
module bcd_digit_chain
  import stopwatch_pkg::*;
#(
  parameter int NUM_DIGITS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clear_i,
  input  logic                        inc_i,
  output logic [NUM_DIGITS*BCD_W-1:0] digits_o
);
  logic [NUM_DIGITS:0] carry;
  assign carry[0] = inc_i;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    bcd_t d_q;
    always_ff @(posedge clk) begin
      if (rst || clear_i)  d_q <= '0;
      else if (carry[g])   d_q <= (d_q == BCD_MAX) ? bcd_t'(0) : d_q + bcd_t'(1);
    end
    assign carry[g+1] = carry[g] & (d_q == BCD_MAX);
    assign digits_o[g*BCD_W +: BCD_W] = d_q;

    // R4
    digit_range_chk: assert property (@(posedge clk) disable iff (rst)
      d_q <= BCD_MAX);
    // R4
    digit_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (carry[g] && !clear_i && d_q == BCD_MAX) |=> d_q == '0);
  end

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> digits_o == '0);
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!inc_i && !clear_i) |=> $stable(digits_o));
endmodule

// File: rtl/seg7_encode.sv
module seg7_encode
  import stopwatch_pkg::*;
(
  input  bcd_t digit_i,
  output seg_t seg_o
);
  // active low, bit order g..a
  always_comb begin
    case (digit_i)
      4'd0:    seg_o = 7'b1000000;
      4'd1:    seg_o = 7'b1111001;
      4'd2:    seg_o = 7'b0100100;
      4'd3:    seg_o = 7'b0110000;
      4'd4:    seg_o = 7'b0011001;
      4'd5:    seg_o = 7'b0010010;
      4'd6:    seg_o = 7'b0000010;
      4'd7:    seg_o = 7'b1111000;
      4'd8:    seg_o = 7'b0000000;
      4'd9:    seg_o = 7'b0010000;
      default: seg_o = SEG_BLANK;
    endcase
  end
endmodule

// File: rtl/stopwatch_lap_top.sv
module stopwatch_lap_top
  import stopwatch_pkg::*;
#(
  parameter int NUM_DIGITS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        key_mode_n,
  input  logic                        key_lap_n,
  input  logic                        tick_en,
  output logic [NUM_DIGITS*SEG_W-1:0] seg_o,
  output logic                        mode_clear_o,
  output logic                        mode_run_o,
  output logic                        mode_stop_o
);
  localparam int TIME_W = NUM_DIGITS * BCD_W;
  localparam int DISP_W = NUM_DIGITS * SEG_W;

  logic              mode_press, lap_press;
  logic [2:0]        mode_q;
  logic              in_clr, in_run, in_stop;
  logic [TIME_W-1:0] live_time, lap_q, shown_time;
  logic              show_lap_q;
  logic [DISP_W-1:0] seg_next, seg_q;

  key_press_detect #(.SYNC_STAGES(SYNC_STAGES)) u_mode_key (
    .clk(clk), .rst(rst), .key_n_i(key_mode_n), .press_o(mode_press));
  key_press_detect #(.SYNC_STAGES(SYNC_STAGES)) u_lap_key (
    .clk(clk), .rst(rst), .key_n_i(key_lap_n), .press_o(lap_press));

  assign in_clr  = mode_q[0];
  assign in_run  = mode_q[1];
  assign in_stop = mode_q[2];

  always_ff @(posedge clk) begin
    if (rst)             mode_q <= MODE_CLR;
    else if (mode_press) mode_q <= {mode_q[1:0], mode_q[2]};
  end

  bcd_digit_chain #(.NUM_DIGITS(NUM_DIGITS)) u_live (
    .clk(clk), .rst(rst), .clear_i(in_clr), .inc_i(in_run & tick_en),
    .digits_o(live_time));

  always_ff @(posedge clk) begin
    if (rst || in_clr) begin
      lap_q      <= '0;
      show_lap_q <= 1'b0;
    end else if (in_run && lap_press) begin
      lap_q      <= live_time;
      show_lap_q <= ~show_lap_q;
    end
  end

  assign shown_time = show_lap_q ? lap_q : live_time;

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_enc
    seg7_encode u_enc (
      .digit_i(shown_time[g*BCD_W +: BCD_W]),
      .seg_o  (seg_next[g*SEG_W +: SEG_W]));
  end

  always_ff @(posedge clk) begin
    if (rst) seg_q <= {NUM_DIGITS{SEG_ZERO}};
    else     seg_q <= seg_next;
  end

  assign seg_o        = seg_q;
  assign mode_clear_o = in_clr;
  assign mode_run_o   = in_run;
  assign mode_stop_o  = in_stop;

  // R1
  mode_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(mode_q) == 1);
  // R2
  clr_to_run_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_press && in_clr) |=> mode_q == MODE_RUN);
  // R2
  stop_to_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_press && in_stop) |=> mode_q == MODE_CLR);
  // R5
  clear_lap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    in_clr |=> (lap_q == '0 && !show_lap_q));
  // R6
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_stop && !mode_press) |=> $stable(live_time));
  // R7
  lap_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (in_run && lap_press) |=> (lap_q == $past(live_time) && show_lap_q != $past(show_lap_q)));
  // R8
  stop_lap_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (in_stop && !mode_press) |=> ($stable(lap_q) && $stable(show_lap_q)));
endmodule

// File: tb/stopwatch_lap_top_bench.sv
module stopwatch_lap_top_bench;
  localparam int ND = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic key_mode_n = 1'b1;
  logic key_lap_n  = 1'b1;
  logic tick_en    = 1'b0;
  logic [ND*7-1:0] seg_o;
  logic mode_clear_o, mode_run_o, mode_stop_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // bench model
  int m_mode = 0; // 0 clear, 1 run, 2 stop
  int m_live = 0;
  int m_lap  = 0;
  bit m_show = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  stopwatch_lap_top #(.NUM_DIGITS(ND)) u_stopwatch_lap_top (
    .clk(clk), .rst(rst), .key_mode_n(key_mode_n), .key_lap_n(key_lap_n),
    .tick_en(tick_en), .seg_o(seg_o), .mode_clear_o(mode_clear_o),
    .mode_run_o(mode_run_o), .mode_stop_o(mode_stop_o));

  function automatic logic [6:0] pat(input int d);
    case (d)
      0: return 7'h40; 1: return 7'h79; 2: return 7'h24; 3: return 7'h30;
      4: return 7'h19; 5: return 7'h12; 6: return 7'h02; 7: return 7'h78;
      8: return 7'h00; default: return 7'h10;
    endcase
  endfunction

  function automatic logic [ND*7-1:0] expect_seg(input int v);
    logic [ND*7-1:0] r;
    int t = v;
    for (int i = 0; i < ND; i++) begin
      r[i*7 +: 7] = pat(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic check_bits(input string tag, input logic [ND*7-1:0] act,
                            input logic [ND*7-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_mode(input string tag);
    logic [2:0] exp = 3'b001 << m_mode;
    check_bits(tag, {{(ND*7-3){1'b0}}, mode_stop_o, mode_run_o, mode_clear_o},
               {{(ND*7-3){1'b0}}, exp});
  endtask

  task automatic check_disp(input string tag);
    check_bits(tag, seg_o, expect_seg(m_show ? m_lap : m_live));
  endtask

  task automatic press_mode(input int hold);
    @(negedge clk) key_mode_n = 1'b0;
    repeat (hold) @(negedge clk);
    key_mode_n = 1'b1;
    repeat (6) @(negedge clk);
    m_mode = (m_mode + 1) % 3;
    if (m_mode == 0) begin m_live = 0; m_lap = 0; m_show = 1'b0; end
  endtask

  task automatic press_lap();
    @(negedge clk) key_lap_n = 1'b0;
    repeat (3) @(negedge clk);
    key_lap_n = 1'b1;
    repeat (6) @(negedge clk);
    if (m_mode == 1) begin m_lap = m_live; m_show = ~m_show; end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_en = 1'b1;
      @(negedge clk) tick_en = 1'b0;
      if (m_mode == 1) m_live = (m_live + 1) % 10000;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check_mode("R1 reset mode clear");
    check_bits("R9 digit0 zero pattern", {{(ND*7-7){1'b0}}, seg_o[6:0]},
               {{(ND*7-7){1'b0}}, 7'b1000000});
    check_disp("R1 reset display zero");
  endtask

  task automatic t_count();
    press_mode(2);
    check_mode("R2 clear to run");
    ticks(12);
    check_disp("R6 count 12");
    check_bits("R9 digit1 one pattern", {{(ND*7-7){1'b0}}, seg_o[13:7]},
               {{(ND*7-7){1'b0}}, 7'b1111001});
    ticks(88);
    check_disp("R4 carry to 100");
  endtask

  task automatic t_lap();
    press_lap();
    check_disp("R7 lap shown after capture");
    ticks(5);
    check_disp("R7 lap held while live runs");
    press_lap();
    check_disp("R7 second press shows live");
  endtask

  task automatic t_stop();
    press_mode(2);
    check_mode("R2 run to stop");
    ticks(5);
    check_disp("R6 stopped holds");
    press_lap();
    check_disp("R8 lap ignored in stop");
  endtask

  task automatic t_hold();
    press_mode(25);
    check_mode("R3 long press one step");
    check_disp("R5 clear zeroes time");
  endtask

  task automatic t_clear_force();
    press_mode(2);
    ticks(4);
    press_lap();
    ticks(2);
    check_disp("R7 lap 4 shown");
    press_mode(2);
    press_mode(2);
    check_mode("R2 stop to clear");
    check_disp("R5 clear shows zero live");
    press_lap();
    check_disp("R8 lap ignored in clear");
    press_mode(2);
    ticks(3);
    check_disp("R5 run after clear shows live");
  endtask

  task automatic t_wrap();
    ticks(9996);
    check_disp("R4 reach 9999");
    ticks(1);
    check_disp("R4 full wrap to zero");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_count();
    t_lap();
    t_stop();
    t_hold();
    t_clear_force();
    t_wrap();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule